// File: doc/BRIEF.md
# Unlock-Gated Configuration Register Port

This block guards a bank of byte-wide configuration registers behind an index/data port pair on a simple strobed I/O bus. Software must write a two-byte entry key to the index port before anything else is honoured. While the port is open, a write to the index port chooses a register and the data port reads or writes it. A distinct exit code closes the port again. A strap input, captured only while cold reset is held, places the port pair at one of two base addresses.

A lock bit inside one configuration register stops writes to every other register. The lock register itself stays writable, so software can unlock again. Cold reset restores every register to its default and recaptures the strap. Warm reset only closes the port and clears the selected index, so the register contents survive it.

Top module: `cfg_port_ctl`

## Requirements
- R1: Two consecutive index-port writes of 87h open the port. Data-port accesses are honoured only while the port is open. Writes to other addresses do not break the sequence.
- R2: An index-port write of AAh while open closes the port. While closed, data-port reads return 00h and data-port writes change nothing.
- R3: The index port is at base+0 and the data port is at base+1. The base is 2Eh when the strap was captured low and 4Eh when it was captured high. Reads of any other address return 00h, and writes to any other address have no effect.
- R4: While not open, an index-port write of any value other than 87h returns the unlock sequence to its start.
- R5: The valid indices are 02h and 07h through FEh. A data read at any other index returns 00h, and a data write to such an index is discarded.
- R6: When bit 5 of register 26h is 1, data writes to every register except 26h are discarded. Register 26h stays writable.
- R7: After cold reset, register i (i not 26h) holds i with its nibbles swapped. Register 26h holds the captured strap in bit 6 and 0 in all other bits. Bit 6 is read-only.
- R8: A read of the index port returns FFh and does not change the port state.
- R9: Warm reset closes the port and sets the selected index to 00h, and it leaves all register contents unchanged.
- R10: The strap is captured only while cold reset is asserted. Later changes on the strap pin move neither the base nor bit 6 of register 26h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold reset, active low, synchronous; restores everything |
| warm_rst_n | input | 1 | Warm reset, active low, synchronous; closes the port only |
| strap_base_sel | input | 1 | Base-address strap, captured during cold reset |
| bus_addr | input | 8 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational while bus_re is high |

## Verification
The unlock path is driven with clean key pairs, keys broken by stray bytes, and keys interleaved with writes to other addresses. These patterns separate an abort on a wrong byte from a sequence that merely needs two writes. A long random mix of index, data and unrelated-address traffic under a fixed seed is compared against a bench model of the open state, the selected index and the register image. This mix shows whether closed-state and invalid-index accesses leak into the registers. Directed passes cover lock set and clear, warm reset against cold reset, and both strap settings with the strap toggled after reset. These passes show whether retention and base selection depend on the right reset.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int CFG_DW = 8;
  typedef logic [CFG_DW-1:0] cfg_byte_t;

  typedef enum logic [1:0] {
    ST_SHUT = 2'd0,
    ST_HALF = 2'd1,
    ST_OPEN = 2'd2
  } unlock_st_e;

  // index decode: one isolated index plus one contiguous range
  function automatic logic cfg_idx_valid(input cfg_byte_t idx, input cfg_byte_t solo,
                                         input cfg_byte_t lo, input cfg_byte_t hi);
    return (idx == solo) || ((idx >= lo) && (idx <= hi));
  endfunction

  // cold-reset default of an ordinary register: nibble swap of its index
  function automatic cfg_byte_t cfg_default(input cfg_byte_t idx);
    return {idx[CFG_DW/2-1:0], idx[CFG_DW-1:CFG_DW/2]};
  endfunction

  function automatic cfg_byte_t cfg_base_pick(input logic sel, input cfg_byte_t b_lo,
                                              input cfg_byte_t b_hi);
    return sel ? b_hi : b_lo;
  endfunction

endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
  import cfg_port_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  output logic          idx_hit,
  output logic          dat_hit
);
  logic [AW-1:0] dat_addr;

  assign dat_addr = base + AW'(1);
  assign idx_hit  = (addr == base);
  assign dat_hit  = (addr == dat_addr);
endmodule

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
  import cfg_port_pkg::*;
#(
  parameter cfg_byte_t KEY_ENTER = 8'h87,
  parameter cfg_byte_t KEY_EXIT  = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  cfg_byte_t  wdata,
  output logic       open_o,
  output cfg_byte_t  idx_q
);
  unlock_st_e st_q, st_d;
  cfg_byte_t  idx_d;
  logic       key_hit, exit_hit;

  assign key_hit  = (wdata == KEY_ENTER);
  assign exit_hit = (wdata == KEY_EXIT);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    if (idx_wr) begin
      unique case (st_q)
        ST_SHUT: st_d = key_hit ? ST_HALF : ST_SHUT;
        ST_HALF: st_d = key_hit ? ST_OPEN : ST_SHUT;
        ST_OPEN: begin
          if (exit_hit) st_d = ST_SHUT;
          else          idx_d = wdata;
        end
        default: st_d = ST_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_SHUT;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign open_o = (st_q == ST_OPEN);

  // R1
  fsm_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && st_q == ST_HALF && key_hit) |=> open_o);
  // R2
  fsm_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && open_o && exit_hit) |=> (st_q == ST_SHUT));
  // R4
  fsm_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && !open_o && !key_hit) |=> (st_q == ST_SHUT));
  // R1
  fsm_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_o) |=> $stable(idx_q));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
#(
  parameter cfg_byte_t LOCK_IDX  = 8'h26,
  parameter int        LOCK_BIT  = 5,
  parameter int        STRAP_BIT = 6,
  parameter cfg_byte_t IDX_SOLO  = 8'h02,
  parameter cfg_byte_t IDX_LO    = 8'h07,
  parameter cfg_byte_t IDX_HI    = 8'hFE
) (
  input  logic      clk,
  input  logic      cold_rst_n,
  input  logic      strap_in,
  input  logic      wr_req,
  input  cfg_byte_t idx,
  input  cfg_byte_t wdata,
  output cfg_byte_t rd_data,
  output logic      lock_o
);
  localparam int        NREG  = 1 << CFG_DW;
  localparam cfg_byte_t SMASK = cfg_byte_t'(1) << STRAP_BIT;

  cfg_byte_t rd_arr [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam cfg_byte_t IX = cfg_byte_t'(g);
    if (!cfg_idx_valid(IX, IDX_SOLO, IDX_LO, IDX_HI)) begin : g_hole
      assign rd_arr[g] = '0;
    end else if (IX == LOCK_IDX) begin : g_lockreg
      cfg_byte_t q;
      always_ff @(posedge clk) begin
        if (!cold_rst_n)
          q <= strap_in ? SMASK : '0;
        else if (wr_req && idx == IX)
          q <= (wdata & ~SMASK) | (q & SMASK);
      end
      assign rd_arr[g] = q;
    end else begin : g_plain
      cfg_byte_t q;
      always_ff @(posedge clk) begin
        if (!cold_rst_n)
          q <= cfg_default(IX);
        else if (wr_req && idx == IX && !lock_o)
          q <= wdata;
      end
      assign rd_arr[g] = q;
    end
  end

  assign lock_o  = rd_arr[LOCK_IDX][LOCK_BIT];
  assign rd_data = rd_arr[idx];

  // R6
  lock_block_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (wr_req && lock_o && idx != LOCK_IDX) |=> $stable(rd_data));
  // R7
  strap_ro_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $stable(rd_arr[LOCK_IDX][STRAP_BIT]));
endmodule

// File: rtl/cfg_port_ctl.sv
module cfg_port_ctl
  import cfg_port_pkg::*;
#(
  parameter int        AW        = 8,
  parameter cfg_byte_t BASE_LO   = 8'h2E,
  parameter cfg_byte_t BASE_HI   = 8'h4E,
  parameter cfg_byte_t KEY_ENTER = 8'h87,
  parameter cfg_byte_t KEY_EXIT  = 8'hAA,
  parameter cfg_byte_t LOCK_IDX  = 8'h26,
  parameter int        LOCK_BIT  = 5,
  parameter int        STRAP_BIT = 6
) (
  input  logic          clk,
  input  logic          cold_rst_n,
  input  logic          warm_rst_n,
  input  logic          strap_base_sel,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [7:0]    bus_rdata
);
  localparam cfg_byte_t RD_IDX_PORT = 8'hFF;

  logic          strap_q;
  logic [AW-1:0] base;
  logic          idx_hit, dat_hit, open_w, lock_w, fsm_rst_n;
  logic          idx_wr, dat_wr;
  cfg_byte_t     idx_w, bank_rd;

  always_ff @(posedge clk) begin
    if (!cold_rst_n) strap_q <= strap_base_sel;
  end

  assign base      = AW'(cfg_base_pick(strap_q, BASE_LO, BASE_HI));
  assign fsm_rst_n = cold_rst_n & warm_rst_n;

  cfg_addr_dec #(.AW(AW)) u_dec (
    .addr(bus_addr), .base(base), .idx_hit(idx_hit), .dat_hit(dat_hit)
  );

  assign idx_wr = bus_we & idx_hit;
  assign dat_wr = bus_we & dat_hit & open_w;

  cfg_unlock_fsm #(.KEY_ENTER(KEY_ENTER), .KEY_EXIT(KEY_EXIT)) u_fsm (
    .clk(clk), .rst_n(fsm_rst_n), .idx_wr(idx_wr), .wdata(bus_wdata),
    .open_o(open_w), .idx_q(idx_w)
  );

  cfg_reg_bank #(.LOCK_IDX(LOCK_IDX), .LOCK_BIT(LOCK_BIT), .STRAP_BIT(STRAP_BIT)) u_bank (
    .clk(clk), .cold_rst_n(cold_rst_n), .strap_in(strap_base_sel), .wr_req(dat_wr),
    .idx(idx_w), .wdata(bus_wdata), .rd_data(bank_rd), .lock_o(lock_w)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_re && idx_hit)                bus_rdata = RD_IDX_PORT;
    else if (bus_re && dat_hit && open_w) bus_rdata = bank_rd;
  end

  // R10
  strap_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $past(cold_rst_n) |-> $stable(strap_q));
  // R8
  idx_read_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (bus_re && idx_hit) |-> (bus_rdata == 8'hFF));
  // R2
  shut_read_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (bus_re && dat_hit && !open_w) |-> (bus_rdata == 8'h00));
  // R8
  idx_read_side_chk: assert property (@(posedge clk) disable iff (!fsm_rst_n)
    (bus_re && !bus_we) |=> $stable(open_w));
endmodule

// File: tb/cfg_port_ctl_tb.sv
`timescale 1ns/1ps
module cfg_port_ctl_tb;
  logic clk = 0, cold_rst_n = 0, warm_rst_n = 1, strap = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic we = 0, re = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  logic [7:0] mdl [256];
  int mst;
  logic [7:0] midx, mbase;
  logic mstrap;

  always #2.5 clk = ~clk;

  cfg_port_ctl u_dut (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n), .strap_base_sel(strap),
    .bus_addr(addr), .bus_wdata(wdata), .bus_we(we), .bus_re(re), .bus_rdata(rdata)
  );

  function automatic bit vld(logic [7:0] i);
    return (i == 8'h02) || (i > 8'h06 && i < 8'hFF);
  endfunction

  function automatic logic [7:0] dflt(logic [7:0] i);
    return 8'((i << 4) | (i >> 4));
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    if (a == mbase) return 8'hFF;
    if (a == 8'(mbase + 1) && mst == 2) return vld(midx) ? mdl[midx] : 8'h00;
    return 8'h00;
  endfunction

  task automatic mdl_wr(logic [7:0] a, logic [7:0] d);
    if (a == mbase) begin
      if (mst == 2) begin
        if (d == 8'hAA) mst = 0; else midx = d;
      end else mst = (d == 8'h87) ? mst + 1 : 0;
    end else if (a == 8'(mbase + 1) && mst == 2 && vld(midx)) begin
      if (midx == 8'h26) mdl[8'h26] = (d & 8'hBF) | (mdl[8'h26] & 8'h40);
      else if (!mdl[8'h26][5]) mdl[midx] = d;
    end
  endtask

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %02h exp %02h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
    mdl_wr(a, d);
  endtask

  task automatic rd(logic [7:0] a, string req);
    @(negedge clk); addr = a; re = 1;
    #1; chk(req, rdata, exp_rd(a));
    re = 0;
  endtask

  task automatic rd_fix(logic [7:0] a, logic [7:0] exp, string req);
    @(negedge clk); addr = a; re = 1;
    #1; chk(req, rdata, exp);
    re = 0;
  endtask

  task automatic do_cold(logic s);
    @(negedge clk); strap = s; cold_rst_n = 0;
    repeat (3) @(negedge clk);
    cold_rst_n = 1;
    mstrap = s; mbase = s ? 8'h4E : 8'h2E; mst = 0; midx = 0;
    for (int i = 0; i < 256; i++) mdl[i] = vld(8'(i)) ? dflt(8'(i)) : 8'h00;
    mdl[8'h26] = s ? 8'h40 : 8'h00;
  endtask

  task automatic do_warm();
    @(negedge clk); warm_rst_n = 0;
    repeat (2) @(negedge clk);
    warm_rst_n = 1; mst = 0; midx = 0;
  endtask

  task automatic unlock(); wr(mbase, 8'h87); wr(mbase, 8'h87); endtask
  task automatic sel(logic [7:0] i); wr(mbase, i); endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_cold(0);
    rd_fix(8'h2F, 8'h00, "R2 closed after cold reset");
    rd_fix(8'h2E, 8'hFF, "R8 index port read");
    unlock();
    sel(8'h02); rd_fix(8'h2F, 8'h20, "R7 default CR02");
    sel(8'h07); rd_fix(8'h2F, 8'h70, "R7 default CR07");
    sel(8'h26); rd_fix(8'h2F, 8'h00, "R7 CR26 strap low");
    sel(8'hFE); rd_fix(8'h2F, 8'hEF, "R7 default CRFE");
    // R8: index reads must not disturb the open state or selection
    rd_fix(8'h2E, 8'hFF, "R8 index read while open");
    rd_fix(8'h2F, 8'hEF, "R8 no side effect");
    // R5 invalid index
    sel(8'h05); wr(8'h2F, 8'h5A); rd_fix(8'h2F, 8'h00, "R5 invalid index");
    // R6 lock
    sel(8'h26); wr(8'h2F, 8'h20); rd_fix(8'h2F, 8'h20, "R6 lock bit set");
    sel(8'h07); wr(8'h2F, 8'h33); rd_fix(8'h2F, 8'h70, "R6 write blocked");
    sel(8'h26); wr(8'h2F, 8'hFF); rd_fix(8'h2F, 8'hBF, "R6 CR26 writable, R7 bit6 ro");
    wr(8'h2F, 8'h00);
    sel(8'h07); wr(8'h2F, 8'h33); rd_fix(8'h2F, 8'h33, "R6 write after unlock");
    // R2 exit then data write ignored
    wr(8'h2E, 8'hAA); wr(8'h2F, 8'h99); rd_fix(8'h2F, 8'h00, "R2 closed read");
    unlock(); rd_fix(8'h2F, 8'h33, "R2 closed write dropped");
    // R4 abort
    wr(8'h2E, 8'hAA);
    wr(8'h2E, 8'h87); wr(8'h2E, 8'h55); wr(8'h2E, 8'h87);
    rd_fix(8'h2F, 8'h00, "R4 aborted sequence");
    wr(8'h2E, 8'h87); rd_fix(8'h2F, 8'h33, "R4 restart opens");
    // R1 unrelated writes between keys
    wr(8'h2E, 8'hAA); wr(8'h2E, 8'h87); wr(8'h60, 8'h11); wr(8'h2E, 8'h87);
    sel(8'h07); rd_fix(8'h2F, 8'h33, "R1 key with stray address");
    // R9 warm reset
    do_warm();
    rd_fix(8'h2F, 8'h00, "R9 warm closes");
    unlock(); rd_fix(8'h2F, 8'h00, "R9 index cleared");
    sel(8'h07); rd_fix(8'h2F, 8'h33, "R9 contents kept");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [7:0] v;
      op = $urandom % 10;
      v = 8'($urandom);
      case (op)
        0, 1: begin
          case ($urandom % 4)
            0: v = 8'h87;
            1: v = ($urandom % 6 == 0) ? 8'hAA : v;
            2: v = 8'h07 + 8'($urandom % 8);
            default: v = (($urandom % 8) == 0) ? 8'h26 : v;
          endcase
          wr(mbase, v);
        end
        2, 3: wr(8'(mbase + 1), v);
        4, 5, 6: rd(8'(mbase + 1), (mst != 2) ? "R2 random" : (!vld(midx) ? "R5 random" : "R1 random"));
        7: rd(mbase, "R8 random");
        default: begin
          logic [7:0] a;
          a = 8'($urandom);
          if ($urandom % 2) wr(a, v); else rd(a, "R3 random");
        end
      endcase
    end
    // R3 / R10 strap high
    do_cold(1);
    wr(8'h2E, 8'h87); wr(8'h2E, 8'h87); wr(8'h2E, 8'h07);
    rd_fix(8'h2F, 8'h00, "R3 old base inert");
    rd_fix(8'h2E, 8'h00, "R3 old index port inert");
    unlock(); sel(8'h26); rd_fix(8'h4F, 8'h40, "R7 CR26 strap high");
    @(negedge clk); strap = 0;
    repeat (3) @(negedge clk);
    rd_fix(8'h4F, 8'h40, "R10 strap bit held");
    sel(8'h08); rd_fix(8'h4F, 8'h80, "R10 base held");
    rd_fix(8'h4E, 8'hFF, "R3 high base index read");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule